// File: doc/BRIEF.md
# Device-Key List Hash Message Formatter

This block builds the exact word stream that a SHA-1 engine must absorb to check a repeater's device-key list. After a start pulse it takes the device count and two status bytes, pulls the 5-byte device keys in as a byte stream, and repacks them into 32-bit big-endian words. Each word is offered to the hash engine with a valid/ready handshake together with a 3-bit code that tells the engine how many bits of that word are real message text; the remainder is filled by the engine from an 8-byte secret the block never sees.

After the keys, the block appends the status bytes and the slots reserved for the secret, using one of four fixed tail shapes chosen by how many key bytes were left over once the keys stopped filling whole words. It then pads with zero words up to the last word of a 64-byte block, sends the message length in bits, pulses a finish command to the engine, waits for the engine's done flag and reports pass or fail from the engine's match flag. A device count of zero is refused at once.

Top module: `ksv_msg_fmt`

## Requirements
- R1: A start with a device count of zero produces, on the next cycle, a result pulse with the reject flag set and pass clear, and no word is offered to the engine.
- R2: Key bytes are packed in arrival order with the first byte of each word in bits 31:24; every such word carries code 0. Codes mean: 0 = 32 text bits, 1 = 24, 2 = 16, 3 = 8, 4 = none.
- R3: While a word is offered and not accepted, the word and its code stay unchanged, and no further word or input byte is taken until it is accepted.
- R4: With no leftover key bytes, the tail is {16'h0, status0, status1} with code 2, then zero with code 4, then zero with code 2.
- R5: With one leftover key byte k, the tail is {8'h0, k, status0, status1} with code 1, then zero with code 4, then zero with code 3.
- R6: With two leftover key bytes k0,k1, the tail is {k0, k1, status0, status1} with code 0, then two zero words with code 4.
- R7: With three leftover key bytes k0..k2, the tail is {k0, k1, k2, status0} with code 0, then {24'h0, status1} with code 3, then zero with code 4, then zero with code 1.
- R8: After the tail, zero words with code 0 follow until the count of words sent is 15 modulo 16 (byte offset 60 within a 64-byte block).
- R9: The final word is (count × 5 + 10) × 8 with code 0, so the total number of words is a multiple of 16.
- R10: One cycle after the length word is accepted, the finish command pulses for one cycle; on the engine's done flag a one-cycle result pulse reports pass equal to the engine's match flag.
- R11: Out of reset no word is offered, no input byte is requested, and no result or finish pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new message (taken when idle) |
| dev_count | input | 7 | Number of 5-byte device keys |
| stat0 | input | 8 | First status byte |
| stat1 | input | 8 | Second status byte |
| in_byte | input | 8 | Key byte stream |
| in_valid | input | 1 | Key byte present |
| in_ready | output | 1 | Block takes a key byte |
| out_word | output | 32 | Message word to the hash engine |
| out_code | output | 3 | Text-width code of the word |
| out_valid | output | 1 | Word offered |
| out_ready | input | 1 | Engine accepts the word |
| hash_go | output | 1 | Finish-hash command pulse |
| eng_done | input | 1 | Engine finished the hash |
| eng_match | input | 1 | Engine result matched |
| res_valid | output | 1 | Result pulse |
| res_pass | output | 1 | Check passed |
| res_reject | output | 1 | Refused for zero device count |

## Verification
The case that matters is a key word becoming full in the very cycle the key byte stream runs out, so that sending the last full word and choosing the zero-leftover tail meet; device counts of 4 and 16 provoke it, and the bench judges it by the word after the last key word being the 16-bit-text status word. Back-pressure is applied on both the byte input and the word output with a pseudo-random pattern, so a stalled word can coincide with the end of the keys, the tail switch or the padding-to-length step; every accepted word is compared in order against a scoreboard built from the requirements and every stalled word is checked for stability.

// File: rtl/ksv_msg_fmt.sv
module ksv_msg_fmt #(
  parameter int MAX_DEV = 127,
  localparam int DW = $clog2(MAX_DEV + 1),
  localparam int RW = $clog2(MAX_DEV * 5 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dev_count,
  input  logic [7:0]    stat0,
  input  logic [7:0]    stat1,
  input  logic [7:0]    in_byte,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [31:0]   out_word,
  output logic [2:0]    out_code,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          hash_go,
  input  logic          eng_done,
  input  logic          eng_match,
  output logic          res_valid,
  output logic          res_pass,
  output logic          res_reject
);
  typedef enum logic [2:0] {IDLE, GATHER, SEND, TAIL, PAD, HASH, WAIT} st_t;

  st_t           st;
  logic [31:0]   acc;
  logic [2:0]    nb;
  logic [RW-1:0] rem;
  logic [1:0]    left, tstep;
  logic [3:0]    widx;
  logic [DW-1:0] n_q;
  logic [7:0]    s0, s1;
  logic [31:0]   tail_w, len_w;
  logic [2:0]    tail_c;
  logic          tail_last;

  assign in_ready  = (st == GATHER) && (nb != 3'd4) && (rem != '0);
  assign out_valid = (st == SEND) || (st == TAIL) || (st == PAD);
  assign hash_go   = (st == HASH);
  assign len_w     = 32'(n_q) * 32'd40 + 32'd80;
  assign tail_last = (left == 2'd3) ? (tstep == 2'd3) : (tstep == 2'd2);

  always_comb begin
    tail_w = 32'h0;
    tail_c = 3'd4;
    case ({left, tstep})
      4'b00_00: begin tail_w = {16'h0, s0, s1}; tail_c = 3'd2; end
      4'b00_10: tail_c = 3'd2;
      4'b01_00: begin tail_w = {8'h0, acc[31:24], s0, s1}; tail_c = 3'd1; end
      4'b01_10: tail_c = 3'd3;
      4'b10_00: begin tail_w = {acc[31:16], s0, s1}; tail_c = 3'd0; end
      4'b11_00: begin tail_w = {acc[31:8], s0}; tail_c = 3'd0; end
      4'b11_01: begin tail_w = {24'h0, s1}; tail_c = 3'd3; end
      4'b11_11: tail_c = 3'd1;
      default: ;
    endcase
  end

  always_comb begin
    out_word = 32'h0;
    out_code = 3'd0;
    case (st)
      SEND: out_word = acc;
      TAIL: begin out_word = tail_w; out_code = tail_c; end
      PAD:  out_word = (widx == 4'd15) ? len_w : 32'h0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; acc <= '0; nb <= '0; rem <= '0; left <= '0; tstep <= '0;
      widx <= '0; n_q <= '0; s0 <= '0; s1 <= '0;
      res_valid <= 1'b0; res_pass <= 1'b0; res_reject <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        IDLE: if (start) begin
          if (dev_count == '0) begin
            res_valid <= 1'b1; res_pass <= 1'b0; res_reject <= 1'b1;
          end else begin
            n_q <= dev_count; s0 <= stat0; s1 <= stat1;
            rem <= RW'(dev_count) * RW'(5);
            acc <= '0; nb <= '0; widx <= '0; res_reject <= 1'b0;
            st <= GATHER;
          end
        end
        GATHER: begin
          if (nb == 3'd4) st <= SEND;
          else if (rem == '0) begin
            left <= nb[1:0]; tstep <= '0; st <= TAIL;
          end else if (in_valid) begin
            acc[{~nb[1:0], 3'b000} +: 8] <= in_byte;
            nb  <= nb + 3'd1;
            rem <= rem - RW'(1);
          end
        end
        SEND: if (out_ready) begin
          acc <= '0; nb <= '0; widx <= widx + 4'd1; st <= GATHER;
        end
        TAIL: if (out_ready) begin
          widx <= widx + 4'd1; tstep <= tstep + 2'd1;
          if (tail_last) st <= PAD;
        end
        PAD: if (out_ready) begin
          widx <= widx + 4'd1;
          if (widx == 4'd15) st <= HASH;
        end
        HASH: st <= WAIT;
        WAIT: if (eng_done) begin
          res_valid <= 1'b1; res_pass <= eng_match; st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R3
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_code));
  // R3
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, out_valid, hash_go}));
  // R1
  zero_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) && start && (dev_count == '0) |=> res_valid && res_reject && !res_pass && !out_valid);
  // R10
  hash_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hash_go |-> $past(out_valid && out_ready));
  // R10
  hash_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hash_go |=> !hash_go && !out_valid);
  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_code <= 3'd4);
endmodule

// File: tb/ksv_msg_fmt_test.sv
module ksv_msg_fmt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  dev_count = '0;
  logic [7:0]  stat0 = '0, stat1 = '0;
  logic [7:0]  in_byte;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] out_word;
  logic [2:0]  out_code;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        hash_go;
  logic        eng_done = 1'b0;
  logic        eng_match = 1'b0;
  logic        res_valid, res_pass, res_reject;

  always #10 clk = ~clk;

  ksv_msg_fmt uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_count(dev_count),
    .stat0(stat0), .stat1(stat1), .in_byte(in_byte), .in_valid(in_valid),
    .in_ready(in_ready), .out_word(out_word), .out_code(out_code),
    .out_valid(out_valid), .out_ready(out_ready), .hash_go(hash_go),
    .eng_done(eng_done), .eng_match(eng_match), .res_valid(res_valid),
    .res_pass(res_pass), .res_reject(res_reject)
  );

  int total = 0, bad = 0;
  logic [7:0]  kb [0:1023];
  int          bidx = 0;
  logic [34:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] lfsr = 16'hACE1;
  int          done_cnt = 0;
  bit          hold_pend = 0;
  logic [31:0] hold_w;
  logic [2:0]  hold_c;

  assign in_byte = kb[bidx];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void push(input logic [2:0] c, input logic [31:0] w, input string t);
    exp_q.push_back({c, w});
    tag_q.push_back(t);
  endfunction

  // monitor / scoreboard and reactive stimulus
  initial begin
    forever begin
      bit take;
      take = 0;
      @(negedge clk);
      if (rst_n) begin
        if (hold_pend)
          check(out_valid && out_word == hold_w && out_code == hold_c, "R3",
                {29'h0, out_code, out_word}, {29'h0, hold_c, hold_w});
        hold_pend = out_valid && !out_ready;
        hold_w = out_word; hold_c = out_code;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) check(0, "R1 unexpected word", {29'h0, out_code, out_word}, 64'h0);
          else begin
            logic [34:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({out_code, out_word} == e, t, {29'h0, out_code, out_word}, {29'h0, e});
          end
        end
        if (in_valid && in_ready) take = 1;
        if (hash_go) begin
          check(exp_q.size() == 0, "R10 finish before all words", 64'(exp_q.size()), 64'h0);
          done_cnt = 3;
        end
      end
      @(posedge clk);
      #1;
      if (take) bidx++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[1];
      in_valid  = lfsr[2] | lfsr[3];
      eng_done = 1'b0;
      if (done_cnt > 0) begin
        if (done_cnt == 1) eng_done = 1'b1;
        done_cnt--;
      end
    end
  end

  task automatic run_case(input int n, input logic [7:0] a, input logic [7:0] b,
                          input bit match, input int seed);
    int full, lo, w, wc;
    for (int i = 0; i < 5 * n; i++) kb[i] = 8'((i * 37 + seed) & 255);
    full = (5 * n) / 4;
    lo = (5 * n) % 4;
    for (int i = 0; i < full; i++)
      push(3'd0, {kb[4*i], kb[4*i+1], kb[4*i+2], kb[4*i+3]}, "R2");
    w = 4 * full;
    case (lo)
      0: begin push(3'd2, {16'h0, a, b}, "R4"); push(3'd4, 0, "R4"); push(3'd2, 0, "R4"); wc = full + 3; end
      1: begin push(3'd1, {8'h0, kb[w], a, b}, "R5"); push(3'd4, 0, "R5"); push(3'd3, 0, "R5"); wc = full + 3; end
      2: begin push(3'd0, {kb[w], kb[w+1], a, b}, "R6"); push(3'd4, 0, "R6"); push(3'd4, 0, "R6"); wc = full + 3; end
      default: begin
        push(3'd0, {kb[w], kb[w+1], kb[w+2], a}, "R7"); push(3'd3, {24'h0, b}, "R7");
        push(3'd4, 0, "R7"); push(3'd1, 0, "R7"); wc = full + 4;
      end
    endcase
    while (wc % 16 != 15) begin push(3'd0, 0, "R8"); wc++; end
    push(3'd0, 32'((n * 5 + 10) * 8), "R9");
    @(posedge clk); #1;
    bidx = 0; eng_match = match;
    start = 1'b1; dev_count = 7'(n); stat0 = a; stat1 = b;
    @(posedge clk); #1;
    start = 1'b0;
    do @(negedge clk); while (!res_valid);
    check(res_pass == match && !res_reject, "R10 result", {62'h0, res_reject, res_pass}, {63'h0, match});
    check(exp_q.size() == 0, "R9 word count", 64'(exp_q.size()), 64'h0);
    check(bidx == 5 * n, "R2 bytes taken", 64'(bidx), 64'(5 * n));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) kb[i] = 8'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11
    check(!out_valid && !in_ready && !res_valid && !hash_go, "R11 reset",
          {60'h0, out_valid, in_ready, res_valid, hash_go}, 64'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1
    start = 1'b1; dev_count = 7'd0; stat0 = 8'h12; stat1 = 8'h34;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(res_valid && res_reject && !res_pass && !out_valid, "R1 zero count",
          {61'h0, res_valid, res_reject, res_pass}, 64'h6);
    repeat (4) @(negedge clk);
    check(!out_valid && !in_ready, "R1 stays idle", {62'h0, out_valid, in_ready}, 64'h0);
    run_case(1,   8'hA1, 8'hB2, 1'b1, 5);
    run_case(2,   8'hC3, 8'hD4, 1'b0, 11);
    run_case(3,   8'hE5, 8'hF6, 1'b1, 23);
    run_case(4,   8'h17, 8'h28, 1'b1, 41);
    run_case(13,  8'h39, 8'h4A, 1'b0, 59);
    run_case(16,  8'h5B, 8'h6C, 1'b1, 71);
    run_case(127, 8'h7D, 8'h8E, 1'b1, 97);
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule